// File: doc/BRIEF.md
# Ray Miss-Parking Buffer

This block sits in front of one ray-processing pipeline stage. It hides the latency of fetching shape data for that stage. Each incoming ray arrives with the result of its lookup in a non-blocking L1 cache. The result is a hit flag, the line address and, on a hit, the line data. A hitting ray goes straight on to the pipeline with its data, in the same cycle. A missing ray does not stall the stage. It is parked in a buffer row tagged with the missed line address, and later misses on the same line join that row.

Only the ray that opens a row raises a refill request to the next memory level. When the line comes back on the fill port, the row is marked ready. From the next cycle on, its rays are sent to the pipeline one per cycle, in the order they arrived, each with the returned data. The row is freed when its last ray leaves. The pipeline output has a single slot per cycle, and draining rays win it over new hitting input.

Top module: `ray_park_buffer`

## Requirements
- R1: After reset, out_valid and refill_req_valid are 0, and both a hitting ray and a missing ray are accepted (in_ready 1).
- R2: When no row is draining, a hitting ray is accepted and appears on out_ray/out_data in the same cycle, with out_valid 1.
- R3: A miss on a line with no waiting row is accepted, opens a row, and raises refill_req_valid with refill_req_addr equal to in_addr in that cycle. It produces no output.
- R4: A miss on a line that already has a waiting row is accepted into that row without a refill request.
- R5: A fill whose address matches a waiting row makes that row's rays leave on consecutive cycles, starting the cycle after the fill. They leave in arrival order, each with the fill data, and then out_valid returns to 0.
- R6: Hitting rays keep passing through while missed rays wait for their line.
- R7: While any row is draining, a hitting ray is refused (in_ready 0), but a miss on another line is still accepted and requested.
- R8: A row holds 8 rays. A ninth miss on the same waiting line is refused (in_ready 0).
- R9: With all 4 rows in use, a miss on a new line is refused, while hitting rays are still accepted.
- R10: A fill whose address matches no waiting row produces no output.
- R11: Once a row has drained, a new miss on the same line opens a new row and issues a fresh refill request.
- R12: When several rows are ready, each drains completely before the next one starts. Rays of different rows never interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming ray present |
| in_ready | output | 1 | Incoming ray accepted this cycle |
| in_ray | input | RAY_W | Ray payload |
| in_addr | input | ADDR_W | Cache line address the ray needs |
| in_hit | input | 1 | L1 lookup hit for this ray |
| in_data | input | DATA_W | Line data on a hit |
| refill_req_valid | output | 1 | Refill request to next level |
| refill_req_addr | output | ADDR_W | Line address requested |
| fill_valid | input | 1 | Returned line present |
| fill_addr | input | ADDR_W | Address of returned line |
| fill_data | input | DATA_W | Returned line data |
| out_valid | output | 1 | Ray issued to pipeline |
| out_ray | output | RAY_W | Issued ray payload |
| out_data | output | DATA_W | Line data accompanying the ray |

## Verification
A wrong row tag or count shows at the ports within one cycle of the next miss on that line. It appears as a duplicate or missing refill request, or as a wrong in_ready at the row limit. A corrupted slot pointer or drain state shows from the first cycle after a fill. Rays then leave out of order, repeat, interleave between rows or never leave. A priority fault shows as out_valid driven by a hit during a drain.

// File: rtl/ray_park_buffer.sv
module ray_park_buffer #(
  parameter int RAY_W  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ROWS   = 4,
  parameter int SLOTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RAY_W-1:0]  in_ray,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_hit,
  input  logic [DATA_W-1:0] in_data,
  output logic              refill_req_valid,
  output logic [ADDR_W-1:0] refill_req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              out_valid,
  output logic [RAY_W-1:0]  out_ray,
  output logic [DATA_W-1:0] out_data
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW = $clog2(SLOTS + 1);

  logic [ROWS-1:0]   row_vld, row_fill;
  logic [ADDR_W-1:0] row_tag  [ROWS];
  logic [DATA_W-1:0] row_data [ROWS];
  logic [CW-1:0]     row_cnt  [ROWS];
  logic [RAY_W-1:0]  slot     [ROWS][SLOTS];

  logic          busy;
  logic [RW-1:0] cur_row;
  logic [CW-1:0] rd_cnt;

  logic          match_any, free_any, ready_any, fill_hit;
  logic [RW-1:0] match_row, free_row, ready_row, fill_row;

  always_comb begin
    match_any = 1'b0; match_row = '0;
    free_any  = 1'b0; free_row  = '0;
    ready_any = 1'b0; ready_row = '0;
    fill_hit  = 1'b0; fill_row  = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_vld[r] && !row_fill[r] && row_tag[r] == in_addr) begin
        match_any = 1'b1; match_row = RW'(r);
      end
      if (!row_vld[r]) begin
        free_any = 1'b1; free_row = RW'(r);
      end
      if (row_vld[r] && row_fill[r]) begin
        ready_any = 1'b1; ready_row = RW'(r);
      end
      if (row_vld[r] && !row_fill[r] && row_tag[r] == fill_addr) begin
        fill_hit = 1'b1; fill_row = RW'(r);
      end
    end
  end

  logic          drain_go, can_park, take, park, alloc, last;
  logic [RW-1:0] drain_row, tgt;

  assign drain_row = busy ? cur_row : ready_row;
  assign drain_go  = busy | ready_any;
  assign can_park  = match_any ? (row_cnt[match_row] != CW'(SLOTS)) : free_any;
  assign in_ready  = in_hit ? !drain_go : can_park;
  assign take      = in_valid & in_ready;
  assign park      = take & !in_hit;
  assign alloc     = park & !match_any;
  assign tgt       = match_any ? match_row : free_row;
  assign last      = (rd_cnt + CW'(1)) == row_cnt[drain_row];

  assign refill_req_valid = alloc;
  assign refill_req_addr  = in_addr;
  assign out_valid = drain_go | (take & in_hit);
  assign out_ray   = drain_go ? slot[drain_row][SW'(rd_cnt)] : in_ray;
  assign out_data  = drain_go ? row_data[drain_row] : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_vld  <= '0;
      row_fill <= '0;
      busy     <= 1'b0;
      cur_row  <= '0;
      rd_cnt   <= '0;
      for (int r = 0; r < ROWS; r++) row_cnt[r] <= '0;
    end else begin
      if (park) begin
        slot[tgt][SW'(row_cnt[tgt])] <= in_ray;
        row_cnt[tgt] <= row_cnt[tgt] + CW'(1);
        if (alloc) begin
          row_vld[tgt]  <= 1'b1;
          row_fill[tgt] <= 1'b0;
          row_tag[tgt]  <= in_addr;
        end
      end
      if (fill_valid && fill_hit) begin
        row_fill[fill_row] <= 1'b1;
        row_data[fill_row] <= fill_data;
      end
      if (drain_go) begin
        if (last) begin
          row_vld[drain_row]  <= 1'b0;
          row_fill[drain_row] <= 1'b0;
          row_cnt[drain_row]  <= '0;
          busy   <= 1'b0;
          rd_cnt <= '0;
        end else begin
          busy    <= 1'b1;
          cur_row <= drain_row;
          rd_cnt  <= rd_cnt + CW'(1);
        end
      end
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row_chk
    // R8
    slot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_cnt[g] <= CW'(SLOTS));
    // R5
    live_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_vld[g] |-> row_cnt[g] != '0);
  end

  // R7
  drain_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || |(row_vld & row_fill)) |-> !(in_valid && in_hit && in_ready));

  // R12
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (row_vld[cur_row] && row_fill[cur_row] && out_valid));

  // R3
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_valid |=> !(refill_req_valid && refill_req_addr == $past(refill_req_addr)));
endmodule

// File: tb/sim_ray_park_buffer.sv
module sim_ray_park_buffer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_hit = 1'b0, fill_valid = 1'b0;
  logic [15:0] in_ray = '0;
  logic [11:0] in_addr = '0, fill_addr = '0;
  logic [31:0] in_data = '0, fill_data = '0;
  logic        in_ready, refill_req_valid, out_valid;
  logic [11:0] refill_req_addr;
  logic [15:0] out_ray;
  logic [31:0] out_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ray_park_buffer u0 (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit iv, bit ih, int ray, int addr, int data,
                     bit fv = 0, int fa = 0, int fd = 0);
    @(negedge clk);
    in_valid = iv; in_hit = ih; in_ray = 16'(ray); in_addr = 12'(addr);
    in_data = 32'(data); fill_valid = fv; fill_addr = 12'(fa); fill_data = 32'(fd);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic exp_out(string req, bit v, int ray = 0, int data = 0);
    chk(req, "out_valid", out_valid, v);
    if (v) begin
      chk(req, "out_ray", out_ray, ray);
      chk(req, "out_data", out_data, data);
    end
  endtask

  task automatic t_reset();
    cyc(1, 1, 1, 1, 1); chk("R1", "in_ready hit", in_ready, 1);
    in_valid = 0; #0.5;
    chk("R1", "out_valid idle", out_valid, 0);
    chk("R1", "refill idle", refill_req_valid, 0);
    in_hit = 0; #0.1;
    chk("R1", "in_ready miss", in_ready, 1);
  endtask

  task automatic t_hit();
    cyc(1, 1, 5, 3, 'hAAAA);
    chk("R2", "in_ready", in_ready, 1);
    exp_out("R2", 1, 5, 'hAAAA);
    chk("R2", "refill", refill_req_valid, 0);
  endtask

  task automatic t_group();
    cyc(1, 0, 10, 'h10, 0);
    chk("R3", "in_ready", in_ready, 1);
    chk("R3", "refill", refill_req_valid, 1);
    chk("R3", "refill_addr", refill_req_addr, 'h10);
    exp_out("R3", 0);
    cyc(1, 0, 11, 'h10, 0);
    chk("R4", "in_ready", in_ready, 1);
    chk("R4", "refill", refill_req_valid, 0);
    cyc(1, 1, 20, 'h77, 'h2020);
    exp_out("R6", 1, 20, 'h2020);
    cyc(1, 0, 12, 'h10, 0);
    chk("R4", "refill third", refill_req_valid, 0);
    cyc(0, 0, 0, 0, 0, 1, 'h10, 'hD00D);
    exp_out("R5", 0);
    cyc(1, 1, 21, 'h77, 'h1);
    chk("R7", "hit refused", in_ready, 0);
    exp_out("R5", 1, 10, 'hD00D);
    cyc(1, 0, 30, 'h20, 0);
    chk("R7", "miss accepted", in_ready, 1);
    chk("R7", "miss refill", refill_req_valid, 1);
    exp_out("R5", 1, 11, 'hD00D);
    idle(); exp_out("R5", 1, 12, 'hD00D);
    idle(); exp_out("R5", 0);
    cyc(0, 0, 0, 0, 0, 1, 'h20, 'hE);
    idle(); exp_out("R5", 1, 30, 'hE);
    idle(); exp_out("R5", 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 40 + i, 'h40, 0);
      chk("R8", "slot accepted", in_ready, 1);
    end
    cyc(1, 0, 48, 'h40, 0);
    chk("R8", "ninth refused", in_ready, 0);
    cyc(0, 0, 0, 0, 0, 1, 'h40, 'h4444);
    for (int i = 0; i < 8; i++) begin
      idle(); exp_out("R5", 1, 40 + i, 'h4444);
    end
    idle(); exp_out("R5", 0);
  endtask

  task automatic t_rows();
    cyc(1, 0, 60, 'h50, 0);
    cyc(1, 0, 61, 'h51, 0);
    cyc(1, 0, 62, 'h52, 0);
    cyc(1, 0, 63, 'h53, 0);
    cyc(1, 0, 64, 'h52, 0);
    chk("R9", "join while full", in_ready, 1);
    cyc(1, 0, 65, 'h54, 0);
    chk("R9", "fifth line refused", in_ready, 0);
    chk("R9", "no refill", refill_req_valid, 0);
    cyc(1, 1, 66, 'h54, 'h66);
    chk("R9", "hit accepted", in_ready, 1);
    exp_out("R9", 1, 66, 'h66);
    cyc(0, 0, 0, 0, 0, 1, 'h99, 'h9);
    idle(); exp_out("R10", 0);
    cyc(0, 0, 0, 0, 0, 1, 'h52, 'hB2);
    cyc(0, 0, 0, 0, 0, 1, 'h50, 'hB0);
    exp_out("R12", 1, 62, 'hB2);
    idle(); exp_out("R12", 1, 64, 'hB2);
    idle(); exp_out("R12", 1, 60, 'hB0);
    idle(); exp_out("R12", 0);
    cyc(0, 0, 0, 0, 0, 1, 'h51, 'hB1);
    cyc(0, 0, 0, 0, 0, 1, 'h53, 'hB3);
    exp_out("R12", 1, 61, 'hB1);
    idle(); exp_out("R12", 1, 63, 'hB3);
    idle(); exp_out("R12", 0);
  endtask

  task automatic t_reuse();
    cyc(1, 0, 70, 'h10, 0);
    chk("R11", "fresh refill", refill_req_valid, 1);
    chk("R11", "refill_addr", refill_req_addr, 'h10);
    cyc(0, 0, 0, 0, 0, 1, 'h10, 'h71);
    idle(); exp_out("R11", 1, 70, 'h71);
    idle(); exp_out("R11", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_hit();
    t_group();
    t_full();
    t_rows();
    t_reuse();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule